// File: doc/BRIEF.md
# Page Owner Private/Shared Classifier

This block keeps one classification record per memory page and uses it to tag every memory access as private or shared. A request carries a core number and an address. The block turns the address into a page number by dropping the low `PAGE_SHIFT` bits, and uses that page number to index a table directly. Each table record holds three things: a touched flag, the owning core and a shared flag. The requester uses the returned bit to choose between its private cache and the distributed shared cache before it does the lookup.

The first core to touch a page becomes its owner, and the page starts out private. When a different core later touches that page, the page becomes shared for good. At that moment the block emits a single-cycle notice naming the page and its former owner, so the address translation state of that owner can be corrected. A release input returns a record to the untouched state, which models the page being freed. Page granularity is a parameter. The default is 4 KB pages, and the block works down to 64-byte blocks.

Top module: `page_class_unit`

## Requirements
- R1: An access to an untouched page inside the table is answered private (`resp_shared`=0). The requesting core is recorded as owner and no update notice is raised.
- R2: An access by the recorded owner to a page that is still private is answered private.
- R3: An access by a core other than the owner to a private page is itself answered shared, and from then on the page is shared.
- R4: That private-to-shared change raises `upd_valid` for exactly one cycle, together with the response. `upd_page` carries the page number and `upd_owner` carries the former owner. `upd_valid` is never raised in any other case.
- R5: Once a page is shared, every access to it, including one by the former owner, is answered shared, and no further notice is raised.
- R6: An accepted request (`req_valid`=1 at a rising edge) gives `resp_valid`=1 in the following cycle with its classification. Without a request, `resp_valid` is 0.
- R7: A page number at or above `NUM_ENTRIES` is answered shared. It changes no record and raises no notice.
- R8: `free_valid` with `free_page` returns that record to untouched, so the next access to it is a first touch. An access in the same cycle is judged on the record as it stood before that cycle, and the release still takes effect. A release outside the table is ignored.
- R9: The page number is `req_addr >> PAGE_SHIFT`. Two addresses that differ only in the low `PAGE_SHIFT` bits share one record, and neighbouring pages keep separate records.
- R10: After synchronous active-low reset, every record is untouched and `resp_valid` and `upd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_core | input | CORE_W | Requesting core number |
| req_addr | input | ADDR_W | Access address |
| free_valid | input | 1 | Release a page record |
| free_page | input | ADDR_W-PAGE_SHIFT | Page number to release |
| resp_valid | output | 1 | Classification valid, one cycle after the request |
| resp_shared | output | 1 | 1 = shared, 0 = private |
| upd_valid | output | 1 | One-cycle private-to-shared notice |
| upd_page | output | ADDR_W-PAGE_SHIFT | Page that became shared |
| upd_owner | output | CORE_W | Core that owned that page |

## Verification
The assertions check several behaviours on every cycle:
- a request is always followed by a response;
- a notice never comes without a shared response;
- out-of-range pages are always shared and never raise a notice;
- a shared record stays shared unless it is released;
- an owner never changes while a record is touched;
- a newly touched record always starts private.

Other behaviours can only be shown by the bench's scenarios, where the cycle-by-cycle reference model compares every output:
- that the foreign-core access is the one that flips a page;
- the exact page number and former owner carried by the notice;
- that addresses within one page share a record;
- how a release interacts with an access in the same cycle.

// File: rtl/pgcls_pkg.sv
// Package: shared types for the page classifier.
// It holds the access outcome encoding and the function that picks it.
package pgcls_pkg;

    // What a single access does to its page record.
    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,  // no request
        ACC_FIRST   = 3'd1,  // untouched page, requester becomes owner
        ACC_OWNER   = 3'd2,  // owner hits its own private page
        ACC_FOREIGN = 3'd3,  // other core hits a private page: turn shared
        ACC_SHARED  = 3'd4,  // page already shared
        ACC_OUTSIDE = 3'd5   // page number outside the table
    } acc_kind_e;

    // Pick the outcome from request presence, range and the record fields.
    function automatic acc_kind_e pick_kind(input logic req,
                                            input logic in_range,
                                            input logic touched,
                                            input logic shared,
                                            input logic owner_match);
        if (!req)              return ACC_NONE;
        else if (!in_range)    return ACC_OUTSIDE;
        else if (!touched)     return ACC_FIRST;
        else if (shared)       return ACC_SHARED;
        else if (owner_match)  return ACC_OWNER;
        else                   return ACC_FOREIGN;
    endfunction

    // Shared answer for each outcome.
    function automatic logic kind_is_shared(input acc_kind_e k);
        return (k == ACC_FOREIGN) || (k == ACC_SHARED) || (k == ACC_OUTSIDE);
    endfunction

endpackage

// File: rtl/page_index.sv
// Module: page_index
// Turns an address into a page number and a table index, and flags
// whether that page falls inside the table.
// Assumes ADDR_W - PAGE_SHIFT >= $clog2(NUM_ENTRIES) and PAGE_SHIFT >= 6.
module page_index #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int NUM_ENTRIES = 64,
    localparam int PN_W       = ADDR_W - PAGE_SHIFT,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PN_W-1:0]   page_num,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range
);
    localparam logic [PN_W:0] LIMIT = (PN_W + 1)'(NUM_ENTRIES);

    // Drop the offset bits, then range-check the page number.
    always_comb begin
        page_num = addr[ADDR_W-1:PAGE_SHIFT];
        idx      = page_num[IDX_W-1:0];
        in_range = ({1'b0, page_num} < LIMIT);
    end
endmodule

// File: rtl/class_table.sv
// Module: class_table
// Holds one record (touched, shared, owner) per page, with one
// combinational read port and one access write port. A release port
// clears a record and wins over an access write to the same index.
// Assumes synchronous active-low reset.
module class_table #(
    parameter int NUM_ENTRIES = 64,
    parameter int CORE_W      = 2,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_touched,
    output logic              rd_shared,
    output logic [CORE_W-1:0] rd_owner,
    input  logic              wr_first,
    input  logic              wr_share,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CORE_W-1:0] wr_owner,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    logic [NUM_ENTRIES-1:0] touched_q;
    logic [NUM_ENTRIES-1:0] shared_q;
    logic [CORE_W-1:0]      owner_q [NUM_ENTRIES];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
            logic clr_hit;
            logic wr_hit;
            assign clr_hit = clr_en && (clr_idx == IDX_W'(gi));
            assign wr_hit  = (wr_idx == IDX_W'(gi));

            // Per-record state: release first, then first touch or share.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_hit) begin
                    touched_q[gi] <= 1'b0;
                    shared_q[gi]  <= 1'b0;
                    owner_q[gi]   <= '0;
                end else if (wr_hit && wr_first) begin
                    touched_q[gi] <= 1'b1;
                    shared_q[gi]  <= 1'b0;
                    owner_q[gi]   <= wr_owner;
                end else if (wr_hit && wr_share) begin
                    shared_q[gi]  <= 1'b1;
                end
            end

            AST_SHARED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                shared_q[gi] && !clr_hit |=> shared_q[gi]); // R5
            AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                touched_q[gi] && !clr_hit |=> touched_q[gi] && $stable(owner_q[gi])); // R3
            AST_TOUCH_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(touched_q[gi]) |-> !shared_q[gi]); // R1
        end
    endgenerate

    // Read port: select the indexed record.
    always_comb begin
        rd_touched = touched_q[rd_idx];
        rd_shared  = shared_q[rd_idx];
        rd_owner   = owner_q[rd_idx];
    end
endmodule

// File: rtl/class_decide.sv
// Module: class_decide
// Decides, in one combinational step, the outcome of an access from the
// record as it stands: which write to make, the answer and whether a
// notice is due. Holds no state.
module class_decide #(
    parameter int CORE_W = 2
) (
    input  logic              req_valid,
    input  logic              in_range,
    input  logic [CORE_W-1:0] req_core,
    input  logic              ent_touched,
    input  logic              ent_shared,
    input  logic [CORE_W-1:0] ent_owner,
    output logic              do_first,
    output logic              do_share,
    output logic              ans_shared,
    output logic              raise_upd
);
    import pgcls_pkg::*;

    acc_kind_e kind;

    // Classify the access and derive the table write and outputs.
    always_comb begin
        kind       = pick_kind(req_valid, in_range, ent_touched, ent_shared,
                               req_core == ent_owner);
        do_first   = (kind == ACC_FIRST);
        do_share   = (kind == ACC_FOREIGN);
        raise_upd  = (kind == ACC_FOREIGN);
        ans_shared = kind_is_shared(kind);
    end
endmodule

// File: rtl/page_class_unit.sv
// Module: page_class_unit (top)
// Classifies each access as private or shared per page, using a
// first-owner rule, and pulses a notice on a page's single
// private-to-shared change. Response and notice are registered:
// they appear one cycle after the request.
// Assumes synchronous active-low reset; NUM_CORES >= 2.
module page_class_unit #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int NUM_ENTRIES = 64,
    parameter int NUM_CORES   = 4,
    localparam int PN_W       = ADDR_W - PAGE_SHIFT,
    localparam int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              free_valid,
    input  logic [PN_W-1:0]   free_page,
    output logic              resp_valid,
    output logic              resp_shared,
    output logic              upd_valid,
    output logic [PN_W-1:0]   upd_page,
    output logic [CORE_W-1:0] upd_owner
);
    logic [PN_W-1:0]   page_num;
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic              ent_touched;
    logic              ent_shared;
    logic [CORE_W-1:0] ent_owner;
    logic              do_first;
    logic              do_share;
    logic              ans_shared;
    logic              raise_upd;
    logic              free_in_range;
    logic [IDX_W-1:0]  free_idx;
    logic              free_en;

    page_index #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_req_index (
        .addr     (req_addr),
        .page_num (page_num),
        .idx      (idx),
        .in_range (in_range)
    );

    // Release address: reuse the index logic on a page number shifted back.
    page_index #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_free_index (
        .addr     ({free_page, {PAGE_SHIFT{1'b0}}}),
        .page_num (),
        .idx      (free_idx),
        .in_range (free_in_range)
    );

    // A release outside the table is dropped.
    always_comb free_en = free_valid && free_in_range;

    class_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .CORE_W      (CORE_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (idx),
        .rd_touched (ent_touched),
        .rd_shared  (ent_shared),
        .rd_owner   (ent_owner),
        .wr_first   (do_first),
        .wr_share   (do_share),
        .wr_idx     (idx),
        .wr_owner   (req_core),
        .clr_en     (free_en),
        .clr_idx    (free_idx)
    );

    class_decide #(
        .CORE_W (CORE_W)
    ) u_decide (
        .req_valid   (req_valid),
        .in_range    (in_range),
        .req_core    (req_core),
        .ent_touched (ent_touched),
        .ent_shared  (ent_shared),
        .ent_owner   (ent_owner),
        .do_first    (do_first),
        .do_share    (do_share),
        .ans_shared  (ans_shared),
        .raise_upd   (raise_upd)
    );

    // Response and notice registers, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_shared <= 1'b0;
            upd_valid   <= 1'b0;
            upd_page    <= '0;
            upd_owner   <= '0;
        end else begin
            resp_valid  <= req_valid;
            resp_shared <= req_valid && ans_shared;
            upd_valid   <= raise_upd;
            if (raise_upd) begin
                upd_page  <= page_num;
                upd_owner <= ent_owner;
            end
        end
    end

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R6
    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid && !upd_valid); // R6
    AST_UPD_WITH_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> resp_valid && resp_shared); // R4
    AST_OUTSIDE_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !in_range |=> resp_shared && !upd_valid); // R7
    AST_FIRST_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_range && !ent_touched |=> !resp_shared && !upd_valid); // R1
endmodule

// File: tb/tb_page_class_unit.sv
module tb_page_class_unit;
    localparam int ADDR_W = 32;
    localparam int SHIFT  = 12;
    localparam int ENT    = 64;
    localparam int PN_W   = ADDR_W - SHIFT;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_core = '0;
    logic [31:0]     req_addr = '0;
    logic            free_valid = 1'b0;
    logic [PN_W-1:0] free_page = '0;
    logic            resp_valid, resp_shared, upd_valid;
    logic [PN_W-1:0] upd_page;
    logic [1:0]      upd_owner;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_touched [ENT];
    bit m_shared  [ENT];
    int m_owner   [ENT];

    always #2.5 clk = ~clk;  // 200 MHz

    page_class_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
        .req_addr(req_addr), .free_valid(free_valid), .free_page(free_page),
        .resp_valid(resp_valid), .resp_shared(resp_shared), .upd_valid(upd_valid),
        .upd_page(upd_page), .upd_owner(upd_owner)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive, predict, step, compare, update model.
    task automatic step(input bit rv, input int core, input int addr,
                        input bit fv, input int fpage);
        int pg;
        bit e_sh, e_upd;
        int e_own;
        string tag;
        @(negedge clk);
        req_valid = rv; req_core = 2'(core); req_addr = 32'(addr);
        free_valid = fv; free_page = PN_W'(fpage);
        pg = addr >>> SHIFT;
        e_sh = 0; e_upd = 0; e_own = 0; tag = "R6";
        if (rv) begin
            if (pg >= ENT) begin e_sh = 1; tag = "R7"; end
            else if (!m_touched[pg]) begin
                tag = "R1"; m_touched[pg] = 1; m_shared[pg] = 0; m_owner[pg] = core;
            end else if (m_shared[pg]) begin e_sh = 1; tag = "R5"; end
            else if (m_owner[pg] == core) tag = "R2";
            else begin e_sh = 1; e_upd = 1; e_own = m_owner[pg]; tag = "R3"; m_shared[pg] = 1; end
        end
        if (fv && fpage < ENT) begin
            m_touched[fpage] = 0; m_shared[fpage] = 0; m_owner[fpage] = 0;
        end
        @(posedge clk);
        #1;
        check("R6", "resp_valid", int'(resp_valid), int'(rv));
        if (rv) check(tag, "resp_shared", int'(resp_shared), int'(e_sh));
        check(e_upd ? "R4" : tag, "upd_valid", int'(upd_valid), int'(e_upd));
        if (e_upd) begin
            check("R4", "upd_page", int'(upd_page), pg);
            check("R4", "upd_owner", int'(upd_owner), e_own);
        end
    endtask

    task automatic acc(input int core, input int addr);
        step(1, core, addr, 0, 0);
    endtask

    initial begin
        int lcg;
        for (int i = 0; i < ENT; i++) begin m_touched[i] = 0; m_shared[i] = 0; m_owner[i] = 0; end
        repeat (4) @(posedge clk);
        #1;
        check("R10", "resp_valid after reset", int'(resp_valid), 0);
        check("R10", "upd_valid after reset", int'(upd_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 0);
        acc(0, 32'h0000_1004);               // R1 first touch
        acc(0, 32'h0000_1FFC);               // R2 / R9 same page
        acc(0, 32'h0000_2000);               // R9 neighbour page, first touch
        acc(1, 32'h0000_1000);               // R3 / R4 foreign access
        acc(0, 32'h0000_1800);               // R5 former owner sees shared
        acc(1, 32'h0000_1000);               // R5 no second notice
        acc(2, 32'h0000_3000);               // back-to-back first touch
        acc(3, 32'h0000_3010);               // then immediate foreign access
        acc(0, 32'h0004_0000);               // R7 page 64 outside
        acc(1, 32'h0004_0000);               // R7 no notice
        step(0, 0, 0, 1, 1);                 // R8 release page 1
        acc(3, 32'h0000_1000);               // R8 first touch again
        acc(0, 32'h0000_1000);               // transition, owner 3
        step(1, 1, 32'h0000_2000, 1, 2);     // R8 access + release same cycle
        acc(1, 32'h0000_2000);               // R8 now a first touch
        step(0, 0, 0, 1, 100);               // R8 release outside table ignored
        acc(2, 32'h0000_2000);               // R3 still owned by core 1
        lcg = 12345;
        for (int i = 0; i < 400; i++) begin
            int core, page, fp;
            bit rv, fv;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fff_ffff;
            core = (lcg >>> 8) & 3;
            page = (lcg >>> 11) % 70;
            rv = ((lcg >>> 4) & 7) != 0;
            fv = ((lcg >>> 20) & 15) == 0;
            fp = (lcg >>> 24) % 66;
            step(rv, core, (page << SHIFT) | ((lcg >>> 2) & 12'hffc), fv, fp);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule